// File: doc/BRIEF.md
# Scanline Display Mode Sequencer

This block is the per-dot timing engine of a scanline display controller. Each clock is one dot step. While the display is switched on, it advances a dot position within the current line and a line counter within the frame. It walks every visible line through sprite-table search, pixel transfer and horizontal blank. The lines below the visible area run in vertical blank. It publishes the current mode as a 2-bit code, the line number, and a line-compare match flag. It also drives two lock outputs that tell the memory arbiter when the processor must be kept away from sprite memory and video memory.

The block also produces the two display-related interrupt requests as one-step pulses. One is the vertical-blank request. The other is the combined status request, which fires on the rising edge of an internal status line. That line is built from the per-mode enables and the line-compare match. The fine horizontal scroll lengthens the transfer phase and can suppress or postpone the status request at horizontal-blank entry. A colour-mode input moves both requests onto a one-step-late path. A double-speed input changes the scroll penalty and the vertical-blank offset.

Top module: `lcd_mode_seq`

## Requirements
- R1: While `lcd_on` is low, one step later `ly` is 0, `mode` is 0, `lyc_match` is 1 (even when `lyc` differs from 0), both locks are 0 and neither request is pulsed.
- R2: Every line after the first takes 456 steps. `ly` counts up by one per line and returns to 0 after line 153.
- R3: The first line after `lcd_on` rises is 4 steps shorter. With step 1 being the first clock with the display on, `ly` becomes 1 at step 452, and line L (L ≥ 1) starts at step 452 + (L−1)·456.
- R4: Mode codes are 0 horizontal blank, 1 vertical blank, 2 search, 3 transfer. Transfer starts at dot 80 of each line below 144. `oam_lock` is 1 exactly in modes 2 and 3, and `vram_lock` is 1 exactly in mode 3.
- R5: Horizontal blank starts at dot 252 + D, where D is taken from the fine scroll latched at transfer start. In single speed, D = ((scx & 7) + (first line ? 2 : 0)) & 4.
- R6: In double speed, D = ((scx & 7) + 1) & 6.
- R7: Lines 1 to 143, and line 0 after a frame wrap, start in mode 2 at dot 0. The first line after enable starts in mode 0.
- R8: Vertical blank starts on line 144 at dot 4 in single speed and dot 2 in double speed. From there `mode` stays 1 until the frame wraps, and `vblank_req` pulses for one step at entry.
- R9: `lyc_match` reflects `ly == lyc` on every step. With `ie_lyc` set, a match drives the status line high.
- R10: The status line is `ie_hblank` in mode 0, `ie_vblank` in mode 1 and `ie_oam` in mode 2, ORed with the compare term. `stat_req` pulses only on a rising edge of that line.
- R11: In single speed, at the step of horizontal-blank entry with (latched scx + first-line offset) & 3 equal to 3, the mode-0 term is masked for that step.
- R12: At horizontal-blank entry with that sum nonzero and not masked, the resulting request comes one step late unless the compare term is also high. With the sum 0, it comes in the entry step.
- R13: With `color_mode` set, both requests come one step after their trigger. The step just before vertical-blank entry also drives the status line when `ie_oam` is set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Dot clock, one step per rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| lcd_on | input | 1 | Display enable |
| dbl_speed | input | 1 | Double-speed timing variant |
| color_mode | input | 1 | Colour-mode request timing |
| ie_hblank | input | 1 | Status source enable, mode 0 |
| ie_vblank | input | 1 | Status source enable, mode 1 |
| ie_oam | input | 1 | Status source enable, mode 2 |
| ie_lyc | input | 1 | Status source enable, line compare |
| scx | input | 8 | Horizontal scroll register |
| lyc | input | 8 | Line compare register |
| ly | output | 8 | Current line number |
| mode | output | 2 | Current mode code |
| lyc_match | output | 1 | Line compare flag |
| oam_lock | output | 1 | Sprite memory blocked for the processor |
| vram_lock | output | 1 | Video memory blocked for the processor |
| stat_req | output | 1 | Status interrupt request pulse |
| vblank_req | output | 1 | Vertical-blank interrupt request pulse |

## Verification
The assertions assume that `lcd_on` and all register inputs change only between clock edges and stay steady for a whole step. The transfer-length property also assumes that `scx` may move at any time, because only the value latched at transfer start matters. The stimulus holds every configuration input constant for the whole time the display is on in a scenario. It changes settings only after dropping `lcd_on`, so each enabled period starts from the shortened first line with a known latched scroll.

// File: rtl/lcd_seq_pkg.sv
package lcd_seq_pkg;

   typedef enum logic [1:0] {
      MD_HBLANK = 2'd0,
      MD_VBLANK = 2'd1,
      MD_SEARCH = 2'd2,
      MD_XFER   = 2'd3
   } lcd_mode_e;

   localparam int DEF_LINE_DOTS   = 456;
   localparam int DEF_SEARCH_DOTS = 80;
   localparam int DEF_XFER_DOTS   = 172;
   localparam int DEF_VIS_LINES   = 144;
   localparam int DEF_TOTAL_LINES = 154;
   localparam int DEF_REG_W       = 8;
   localparam int FIRST_MARK      = 8;   // distance from line end where trimming happens
   localparam int FIRST_TRIM      = 4;   // dots skipped on the first line
   localparam int DLY_1X          = 4;   // vertical-blank offset, single speed
   localparam int DLY_2X          = 2;   // vertical-blank offset, double speed

   // extra transfer dots caused by the fine scroll
   function automatic logic [2:0] fine_delay(input logic [2:0] fine,
                                             input logic       dbl,
                                             input logic       first);
      logic [3:0] t;
      if (dbl) begin
         t = {1'b0, fine} + 4'd1;
         t = t & 4'b0110;
      end else begin
         t = {1'b0, fine} + (first ? 4'd2 : 4'd0);
         t = t & 4'b0100;
      end
      return t[2:0];
   endfunction

endpackage

// File: rtl/lcd_dot_timer.sv
module lcd_dot_timer
   import lcd_seq_pkg::*;
#(
   parameter int LINE_DOTS   = DEF_LINE_DOTS,
   parameter int TOTAL_LINES = DEF_TOTAL_LINES,
   parameter int POS_W       = $clog2(LINE_DOTS),
   parameter int LY_W        = $clog2(TOTAL_LINES)
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             en,
   output logic             first_q,
   output logic [POS_W-1:0] nxt_pos,
   output logic [LY_W-1:0]  nxt_line,
   output logic [LY_W-1:0]  line_q
);

   localparam logic [POS_W:0]  MARK_AT  = (POS_W+1)'(LINE_DOTS - FIRST_MARK);
   localparam logic [POS_W:0]  TRIM     = (POS_W+1)'(FIRST_TRIM);
   localparam logic [POS_W:0]  LINE_END = (POS_W+1)'(LINE_DOTS);
   localparam logic [LY_W-1:0] LAST_LN  = LY_W'(TOTAL_LINES - 1);

   logic [POS_W-1:0] pos_q;
   logic [POS_W:0]   inc;
   logic             nxt_first;

   always_comb begin
      inc       = {1'b0, pos_q} + 1'b1;
      nxt_first = first_q;
      nxt_line  = line_q;
      if (!en) begin
         inc       = '0;
         nxt_line  = '0;
         nxt_first = 1'b1;
      end else begin
         if (first_q && inc >= MARK_AT) begin
            inc       = inc + TRIM;
            nxt_first = 1'b0;
         end
         if (inc >= LINE_END) begin
            inc      = '0;
            nxt_line = (line_q == LAST_LN) ? '0 : line_q + 1'b1;
         end
      end
      nxt_pos = inc[POS_W-1:0];
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         pos_q   <= '0;
         line_q  <= '0;
         first_q <= 1'b1;
      end else begin
         pos_q   <= nxt_pos;
         line_q  <= nxt_line;
         first_q <= nxt_first;
      end
   end

endmodule

// File: rtl/lcd_mode_ctrl.sv
module lcd_mode_ctrl
   import lcd_seq_pkg::*;
#(
   parameter int SEARCH_DOTS     = DEF_SEARCH_DOTS,
   parameter int XFER_DOTS       = DEF_XFER_DOTS,
   parameter int VIS_LINES       = DEF_VIS_LINES,
   parameter int REG_W           = DEF_REG_W,
   parameter int POS_W           = 9,
   parameter int LY_W            = 8,
   parameter bit OAM_LOCK_SEARCH = 1'b1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             en,
   input  logic             dbl,
   input  logic [REG_W-1:0] scx,
   input  logic             first_q,
   input  logic [POS_W-1:0] nxt_pos,
   input  logic [LY_W-1:0]  nxt_line,
   output lcd_mode_e        mode_q,
   output lcd_mode_e        mode_n,
   output logic             hb_entry,
   output logic             vb_entry,
   output logic             pre_vb,
   output logic [1:0]       fine_sum,
   output logic             oam_lock_q,
   output logic             vram_lock_q
);

   localparam logic [POS_W-1:0] XFER_AT = POS_W'(SEARCH_DOTS);
   localparam logic [POS_W-1:0] HB_BASE = POS_W'(SEARCH_DOTS + XFER_DOTS);
   localparam logic [LY_W-1:0]  VIS_LN  = LY_W'(VIS_LINES);

   logic [2:0]       fine_q;
   logic [2:0]       delay;
   logic [POS_W-1:0] hb_at, vb_at;
   logic             visible, search_entry, xfer_entry;
   logic             oam_lock_n;
   logic             unused_scx_hi;

   assign unused_scx_hi = ^scx[REG_W-1:3];

   assign delay    = fine_delay(fine_q, dbl, first_q);
   assign hb_at    = HB_BASE + POS_W'(delay);
   assign vb_at    = dbl ? POS_W'(DLY_2X) : POS_W'(DLY_1X);
   assign fine_sum = fine_q[1:0] + (first_q ? 2'd2 : 2'd0);
   assign visible  = nxt_line < VIS_LN;

   assign search_entry = en && visible && (nxt_pos == '0);
   assign xfer_entry   = en && visible && (nxt_pos == XFER_AT);
   assign hb_entry     = en && visible && (mode_q == MD_XFER) && (nxt_pos == hb_at);
   assign vb_entry     = en && (nxt_line == VIS_LN) && (nxt_pos == vb_at);
   assign pre_vb       = en && (nxt_line == VIS_LN) && (nxt_pos == vb_at - 1'b1);

   always_comb begin
      if (!en)               mode_n = MD_HBLANK;
      else if (vb_entry)     mode_n = MD_VBLANK;
      else if (search_entry) mode_n = MD_SEARCH;
      else if (xfer_entry)   mode_n = MD_XFER;
      else if (hb_entry)     mode_n = MD_HBLANK;
      else                   mode_n = mode_q;
   end

   generate
      if (OAM_LOCK_SEARCH) begin : g_lock_search
         assign oam_lock_n = (mode_n == MD_SEARCH) || (mode_n == MD_XFER);
      end else begin : g_lock_xfer
         assign oam_lock_n = (mode_n == MD_XFER);
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         mode_q      <= MD_HBLANK;
         fine_q      <= '0;
         oam_lock_q  <= 1'b0;
         vram_lock_q <= 1'b0;
      end else begin
         mode_q      <= mode_n;
         oam_lock_q  <= oam_lock_n;
         vram_lock_q <= (mode_n == MD_XFER);
         if (!en || xfer_entry)
            fine_q <= scx[2:0];
      end
   end

endmodule

// File: rtl/lcd_stat_irq.sv
module lcd_stat_irq
   import lcd_seq_pkg::*;
#(
   parameter int REG_W = DEF_REG_W,
   parameter int LY_W  = 8
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             en,
   input  logic             color,
   input  logic             dbl,
   input  logic             ie_hblank,
   input  logic             ie_vblank,
   input  logic             ie_oam,
   input  logic             ie_lyc,
   input  lcd_mode_e        mode_n,
   input  logic             hb_entry,
   input  logic             vb_entry,
   input  logic             pre_vb,
   input  logic [1:0]       fine_sum,
   input  logic [LY_W-1:0]  nxt_line,
   input  logic [REG_W-1:0] lyc,
   output logic             match_q,
   output logic             stat_req_q,
   output logic             vblank_req_q
);

   logic match_n, lyc_hit, mode_src, mask_hb, defer_cand;
   logic line_n, prev_q, rise, late;
   logic stat_late_q, vb_late_q;

   assign match_n = (REG_W'(nxt_line) == lyc);
   assign lyc_hit = ie_lyc && match_n;

   always_comb begin
      unique case (mode_n)
         MD_HBLANK: mode_src = ie_hblank;
         MD_VBLANK: mode_src = ie_vblank;
         MD_SEARCH: mode_src = ie_oam;
         default:   mode_src = 1'b0;
      endcase
   end

   assign mask_hb    = hb_entry && !dbl && (fine_sum == 2'd3);
   assign defer_cand = hb_entry && !mask_hb && (fine_sum != 2'd0);
   assign line_n     = (mode_src && !mask_hb) || lyc_hit || (color && pre_vb && ie_oam);
   assign rise       = line_n && !prev_q;
   assign late       = color || (defer_cand && !lyc_hit);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         match_q      <= 1'b1;
         prev_q       <= 1'b0;
         stat_late_q  <= 1'b0;
         stat_req_q   <= 1'b0;
         vb_late_q    <= 1'b0;
         vblank_req_q <= 1'b0;
      end else if (!en) begin
         match_q      <= 1'b1;
         prev_q       <= 1'b0;
         stat_late_q  <= 1'b0;
         stat_req_q   <= 1'b0;
         vb_late_q    <= 1'b0;
         vblank_req_q <= 1'b0;
      end else begin
         match_q      <= match_n;
         prev_q       <= line_n;
         stat_late_q  <= rise && late;
         stat_req_q   <= (rise && !late) || stat_late_q;
         vb_late_q    <= vb_entry && color;
         vblank_req_q <= (vb_entry && !color) || vb_late_q;
      end
   end

endmodule

// File: rtl/lcd_mode_seq.sv
module lcd_mode_seq
   import lcd_seq_pkg::*;
#(
   parameter int LINE_DOTS       = DEF_LINE_DOTS,
   parameter int SEARCH_DOTS     = DEF_SEARCH_DOTS,
   parameter int XFER_DOTS       = DEF_XFER_DOTS,
   parameter int VIS_LINES       = DEF_VIS_LINES,
   parameter int TOTAL_LINES     = DEF_TOTAL_LINES,
   parameter int REG_W           = DEF_REG_W,
   parameter bit OAM_LOCK_SEARCH = 1'b1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             lcd_on,
   input  logic             dbl_speed,
   input  logic             color_mode,
   input  logic             ie_hblank,
   input  logic             ie_vblank,
   input  logic             ie_oam,
   input  logic             ie_lyc,
   input  logic [REG_W-1:0] scx,
   input  logic [REG_W-1:0] lyc,
   output logic [REG_W-1:0] ly,
   output logic [1:0]       mode,
   output logic             lyc_match,
   output logic             oam_lock,
   output logic             vram_lock,
   output logic             stat_req,
   output logic             vblank_req
);

   localparam int POS_W = $clog2(LINE_DOTS);
   localparam int LY_W  = $clog2(TOTAL_LINES);

   generate
      if (SEARCH_DOTS + XFER_DOTS + 8 > LINE_DOTS - FIRST_MARK) begin : g_bad_line
         $error("line too short for search, transfer and scroll penalty");
      end
      if (VIS_LINES >= TOTAL_LINES) begin : g_bad_frame
         $error("no vertical blank lines");
      end
      if (REG_W < LY_W || REG_W < 3) begin : g_bad_regw
         $error("register width too narrow for line count");
      end
   endgenerate

   logic             first_q;
   logic [POS_W-1:0] nxt_pos;
   logic [LY_W-1:0]  nxt_line, line_q;
   lcd_mode_e        mode_q, mode_n;
   logic             hb_entry, vb_entry, pre_vb;
   logic [1:0]       fine_sum;

   lcd_dot_timer #(
      .LINE_DOTS(LINE_DOTS), .TOTAL_LINES(TOTAL_LINES), .POS_W(POS_W), .LY_W(LY_W)
   ) u_timer (
      .clk(clk), .rst_n(rst_n), .en(lcd_on),
      .first_q(first_q), .nxt_pos(nxt_pos), .nxt_line(nxt_line), .line_q(line_q)
   );

   lcd_mode_ctrl #(
      .SEARCH_DOTS(SEARCH_DOTS), .XFER_DOTS(XFER_DOTS), .VIS_LINES(VIS_LINES),
      .REG_W(REG_W), .POS_W(POS_W), .LY_W(LY_W), .OAM_LOCK_SEARCH(OAM_LOCK_SEARCH)
   ) u_mode (
      .clk(clk), .rst_n(rst_n), .en(lcd_on), .dbl(dbl_speed), .scx(scx),
      .first_q(first_q), .nxt_pos(nxt_pos), .nxt_line(nxt_line),
      .mode_q(mode_q), .mode_n(mode_n), .hb_entry(hb_entry), .vb_entry(vb_entry),
      .pre_vb(pre_vb), .fine_sum(fine_sum),
      .oam_lock_q(oam_lock), .vram_lock_q(vram_lock)
   );

   lcd_stat_irq #(
      .REG_W(REG_W), .LY_W(LY_W)
   ) u_irq (
      .clk(clk), .rst_n(rst_n), .en(lcd_on), .color(color_mode), .dbl(dbl_speed),
      .ie_hblank(ie_hblank), .ie_vblank(ie_vblank), .ie_oam(ie_oam), .ie_lyc(ie_lyc),
      .mode_n(mode_n), .hb_entry(hb_entry), .vb_entry(vb_entry), .pre_vb(pre_vb),
      .fine_sum(fine_sum), .nxt_line(nxt_line), .lyc(lyc),
      .match_q(lyc_match), .stat_req_q(stat_req), .vblank_req_q(vblank_req)
   );

   assign ly   = REG_W'(line_q);
   assign mode = mode_q;

endmodule

// File: rtl/lcd_mode_seq_chk.sv
module lcd_mode_seq_chk #(
   parameter int XFER_DOTS   = 172,
   parameter int VIS_LINES   = 144,
   parameter int TOTAL_LINES = 154,
   parameter int REG_W       = 8
) (
   input logic             clk,
   input logic             rst_n,
   input logic             lcd_on,
   input logic [REG_W-1:0] ly,
   input logic [1:0]       mode,
   input logic             lyc_match,
   input logic             oam_lock,
   input logic             vram_lock,
   input logic             stat_req,
   input logic             vblank_req
);

   logic [15:0] xfer_cnt_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)            xfer_cnt_q <= '0;
      else if (mode == 2'd3) xfer_cnt_q <= xfer_cnt_q + 1'b1;
      else                   xfer_cnt_q <= '0;
   end

   p_off_state_r1: assert property (@(posedge clk) disable iff (!rst_n)
      !lcd_on |=> (ly == '0 && mode == 2'd0 && lyc_match && !oam_lock && !vram_lock
                   && !stat_req && !vblank_req));

   p_ly_range_r2: assert property (@(posedge clk) disable iff (!rst_n)
      ly < REG_W'(TOTAL_LINES));

   p_ly_step_r2: assert property (@(posedge clk) disable iff (!rst_n)
      lcd_on |=> (ly == $past(ly) || ly == $past(ly) + 1'b1 || ly == '0));

   p_vram_lock_r4: assert property (@(posedge clk) disable iff (!rst_n)
      vram_lock |-> (mode == 2'd3 && oam_lock));

   p_oam_lock_r4: assert property (@(posedge clk) disable iff (!rst_n)
      oam_lock |-> mode[1]);

   p_xfer_len_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (mode == 2'd0 && $past(mode) == 2'd3 && $past(lcd_on) && lcd_on) |->
      (xfer_cnt_q >= 16'(XFER_DOTS) && xfer_cnt_q <= 16'(XFER_DOTS + 6) && !xfer_cnt_q[0]));

   p_vblank_mode_r8: assert property (@(posedge clk) disable iff (!rst_n)
      vblank_req |-> (mode == 2'd1 && ly == REG_W'(VIS_LINES)));

endmodule

bind lcd_mode_seq lcd_mode_seq_chk #(
   .XFER_DOTS(XFER_DOTS), .VIS_LINES(VIS_LINES), .TOTAL_LINES(TOTAL_LINES), .REG_W(REG_W)
) u_chk (
   .clk(clk), .rst_n(rst_n), .lcd_on(lcd_on), .ly(ly), .mode(mode),
   .lyc_match(lyc_match), .oam_lock(oam_lock), .vram_lock(vram_lock),
   .stat_req(stat_req), .vblank_req(vblank_req)
);

// File: tb/tb_lcd_mode_seq.sv
module tb_lcd_mode_seq;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       lcd_on = 1'b0, dbl_speed = 1'b0, color_mode = 1'b0;
   logic       ie_hblank = 1'b0, ie_vblank = 1'b0, ie_oam = 1'b0, ie_lyc = 1'b0;
   logic [7:0] scx = '0, lyc = '0;
   logic [7:0] ly;
   logic [1:0] mode;
   logic       lyc_match, oam_lock, vram_lock, stat_req, vblank_req;

   always #5 clk = ~clk;

   lcd_mode_seq dut (
      .clk(clk), .rst_n(rst_n), .lcd_on(lcd_on), .dbl_speed(dbl_speed),
      .color_mode(color_mode), .ie_hblank(ie_hblank), .ie_vblank(ie_vblank),
      .ie_oam(ie_oam), .ie_lyc(ie_lyc), .scx(scx), .lyc(lyc), .ly(ly), .mode(mode),
      .lyc_match(lyc_match), .oam_lock(oam_lock), .vram_lock(vram_lock),
      .stat_req(stat_req), .vblank_req(vblank_req)
   );

   typedef struct {
      int    step;
      int    sig;
      int    val;
      string tag;
   } exp_t;

   exp_t q[$];
   int   n_checks = 0;
   int   n_errors = 0;
   int   cur_step = 0;
   logic en_at_edge = 1'b0;

   localparam int S_MODE = 0, S_LY = 1, S_MATCH = 2, S_OLOCK = 3, S_VLOCK = 4,
                  S_STAT = 5, S_VBL = 6;

   function automatic string sig_name(int s);
      case (s)
         S_MODE:  return "mode";
         S_LY:    return "ly";
         S_MATCH: return "lyc_match";
         S_OLOCK: return "oam_lock";
         S_VLOCK: return "vram_lock";
         S_STAT:  return "stat_req";
         default: return "vblank_req";
      endcase
   endfunction

   function automatic int read_sig(int s);
      case (s)
         S_MODE:  return int'(mode);
         S_LY:    return int'(ly);
         S_MATCH: return int'(lyc_match);
         S_OLOCK: return int'(oam_lock);
         S_VLOCK: return int'(vram_lock);
         S_STAT:  return int'(stat_req);
         default: return int'(vblank_req);
      endcase
   endfunction

   task automatic check(string tag, string what, int act, int exp);
      n_checks++;
      if (act != exp) begin
         n_errors++;
         $display("FAIL %s %s actual=%0d expected=%0d", tag, what, act, exp);
      end
   endtask

   task automatic expect_at(int step, int sig, int val, string tag);
      exp_t e;
      e.step = step; e.sig = sig; e.val = val; e.tag = tag;
      q.push_back(e);
   endtask

   // monitor: count enabled steps and compare queued expectations
   always @(posedge clk) en_at_edge <= lcd_on;

   always @(negedge clk) begin
      if (en_at_edge) cur_step = cur_step + 1;
      else            cur_step = 0;
      while (en_at_edge && q.size() > 0 && q[0].step == cur_step) begin
         exp_t e;
         e = q.pop_front();
         check(e.tag, $sformatf("%s@step%0d", sig_name(e.sig), e.step), read_sig(e.sig), e.val);
      end
   end

   task automatic run_scn(bit dbl, bit col, bit hb, bit vb, bit oam, bit lie,
                          int s, int l, int n);
      @(negedge clk); #1;
      lcd_on = 1'b0;
      repeat (3) @(negedge clk);
      #1;
      dbl_speed = dbl; color_mode = col; ie_hblank = hb; ie_vblank = vb;
      ie_oam = oam; ie_lyc = lie; scx = 8'(s); lyc = 8'(l);
      @(negedge clk); #1;
      lcd_on = 1'b1;
      while (cur_step < n) begin
         @(negedge clk); #1;
      end
      lcd_on = 1'b0;
      while (q.size() > 0) begin
         exp_t e;
         e = q.pop_front();
         check(e.tag, $sformatf("unmatched %s@step%0d", sig_name(e.sig), e.step), 0, 1);
      end
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      n_checks++;
      n_errors++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
      $finish;
   end

   initial begin
      lyc = 8'd5;
      repeat (3) @(negedge clk);
      #1 rst_n = 1'b1;
      repeat (3) @(negedge clk);
      // R1: display off
      check("R1", "ly off", int'(ly), 0);
      check("R1", "mode off", int'(mode), 0);
      check("R1", "lyc_match off", int'(lyc_match), 1);
      check("R1", "locks off", int'({oam_lock, vram_lock}), 0);
      check("R1", "requests off", int'({stat_req, vblank_req}), 0);

      // A: single speed, scx 0, hblank source
      expect_at(1,   S_STAT,  1, "R10");
      expect_at(2,   S_STAT,  0, "R10");
      expect_at(79,  S_MODE,  0, "R7");
      expect_at(80,  S_MODE,  3, "R4");
      expect_at(80,  S_OLOCK, 1, "R4");
      expect_at(80,  S_VLOCK, 1, "R4");
      expect_at(251, S_MODE,  3, "R5");
      expect_at(252, S_MODE,  0, "R5");
      expect_at(252, S_VLOCK, 0, "R4");
      expect_at(252, S_STAT,  0, "R12");
      expect_at(253, S_STAT,  1, "R12");
      expect_at(254, S_STAT,  0, "R10");
      expect_at(300, S_STAT,  0, "R10");
      expect_at(451, S_LY,    0, "R3");
      expect_at(452, S_LY,    1, "R3");
      expect_at(452, S_MODE,  2, "R7");
      expect_at(452, S_OLOCK, 1, "R4");
      expect_at(452, S_VLOCK, 0, "R4");
      expect_at(703, S_MODE,  3, "R5");
      expect_at(704, S_MODE,  0, "R5");
      expect_at(704, S_STAT,  1, "R12");
      run_scn(0, 0, 1, 0, 0, 0, 0, 0, 710);

      // B: single speed, scx 3: penalty on first line, mask on line 1
      expect_at(255, S_MODE, 3, "R5");
      expect_at(256, S_MODE, 0, "R5");
      expect_at(256, S_STAT, 0, "R12");
      expect_at(257, S_STAT, 1, "R12");
      expect_at(704, S_MODE, 0, "R11");
      expect_at(704, S_STAT, 0, "R11");
      expect_at(705, S_STAT, 1, "R11");
      run_scn(0, 0, 1, 0, 0, 0, 3, 0, 710);

      // C: double speed, scx 2
      expect_at(253, S_MODE, 3, "R6");
      expect_at(254, S_MODE, 0, "R6");
      expect_at(254, S_STAT, 1, "R6");
      run_scn(1, 0, 1, 0, 0, 0, 2, 0, 260);

      // F: line compare source
      expect_at(1,   S_MATCH, 0, "R9");
      expect_at(451, S_MATCH, 0, "R9");
      expect_at(452, S_MATCH, 1, "R9");
      expect_at(452, S_STAT,  1, "R9");
      expect_at(453, S_STAT,  0, "R10");
      expect_at(908, S_MATCH, 0, "R9");
      run_scn(0, 0, 0, 0, 0, 1, 0, 1, 910);

      // D: full frame, single speed
      expect_at(65659, S_LY,    143, "R2");
      expect_at(65660, S_LY,    144, "R2");
      expect_at(65663, S_MODE,  0,   "R8");
      expect_at(65663, S_VBL,   0,   "R8");
      expect_at(65664, S_MODE,  1,   "R8");
      expect_at(65664, S_VBL,   1,   "R8");
      expect_at(65665, S_VBL,   0,   "R8");
      expect_at(70219, S_LY,    153, "R2");
      expect_at(70219, S_MODE,  1,   "R8");
      expect_at(70220, S_LY,    0,   "R2");
      expect_at(70220, S_MODE,  2,   "R7");
      expect_at(70220, S_OLOCK, 1,   "R4");
      expect_at(70220, S_VLOCK, 0,   "R4");
      run_scn(0, 0, 0, 0, 0, 0, 0, 0, 70222);

      // E: colour mode, double speed, search source
      expect_at(65661, S_MODE, 0, "R8");
      expect_at(65661, S_STAT, 0, "R13");
      expect_at(65662, S_STAT, 1, "R13");
      expect_at(65662, S_MODE, 1, "R8");
      expect_at(65662, S_VBL,  0, "R13");
      expect_at(65663, S_VBL,  1, "R13");
      run_scn(1, 1, 0, 0, 1, 0, 0, 0, 65665);

      repeat (2) @(negedge clk);
      check("R1", "mode after final disable", int'(mode), 0);

      $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
      $finish;
   end

endmodule